// File: doc/BRIEF.md
# Interrupt-Number Set/Clear CSR Unit

This block sits beside a hart's CSR file and serves the CSRs that set or clear one interrupt pending bit or one interrupt enable bit in a message-signalled interrupt controller. The controller keeps one interrupt file for machine level and one for supervisor level, plus a small set of guest files for virtualized supervisors. A write to one of these CSRs does not carry a bitmap. It carries an interrupt identity. The unit works out the register word and bit position of that identity, then changes only that single bit.

Twelve CSR variants exist. Each of three levels (machine, supervisor, virtual supervisor) has four: set-pending, clear-pending, set-enable and clear-enable. All of them read as zero. On a guest-level access, the hypervisor's guest-file selector picks the target file, and that selector is checked against the number of guest files that are live. The unit also decides on an invalid access and reports it as one of two exception kinds. Both the decision and the bit update belong to the access cycle, and the unit never stalls.

The pending and enable state of every file is brought out as flat vectors, one bit per identity, for the delivery logic and for observation.

Top module: `intnum_csr_unit`

## Requirements
- R1: `csr_sel` encodes the access. Bits [3:2] give the level: 0 = machine, 1 = supervisor, 2 = virtual supervisor, 3 = reserved. Bit 1 picks the array: 1 = pending, 0 = enable. Bit 0 picks the operation: 1 = set, 0 = clear. File 0 is machine, file 1 is supervisor, and file 1+g is guest g.
- R2: `csr_rdata` is zero on every access.
- R3: The identity is `csr_wdata & csr_wmask`. When `xlen64` is 0, only bits [31:0] are used. The register index is (id / XLEN) * (XLEN / 32) and the bit inside the register is id mod XLEN. Identity id of file f therefore lands on bit f*NUM_IDS+id of `pend_o` or `en_o`.
- R4: A set writes 1 and a clear writes 0. No other bit of any file changes, and the new value is visible after the clock edge that closes the access. Reset clears all bits.
- R5: An identity of 0, or one at or above NUM_IDS, changes no state and raises no exception.
- R6: A virtual-supervisor access targets guest file `vgein`. The access is invalid when `vgein` is 0, when it is greater than `geilen`, or when it is greater than NUM_GUESTS.
- R7: While `virt_on` is 1, a supervisor-level access is handled as the matching virtual-supervisor access.
- R8: An access is invalid if it targets a level whose file is absent (parameters HAS_M and HAS_S) or if it uses the reserved level.
- R9: An invalid access raises `exc_virt` when `virt_on` is 1 and the effective level is virtual supervisor. In every other case it raises `exc_illegal`. The exception output is combinational in the access cycle, and the access changes no state.
- R10: A valid access whose write mask is all zero changes nothing and raises no exception. An invalid access with a zero mask still raises its exception.
- R11: When `xlen64` is 0, bits [63:32] of the write data and of the write mask have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | An access to one of the twelve CSRs takes place this cycle |
| csr_sel | input | 4 | Level, array and operation of the access (R1) |
| csr_wdata | input | 64 | Write data |
| csr_wmask | input | 64 | Write mask; all zero for a pure read |
| xlen64 | input | 1 | 1 = XLEN 64, 0 = XLEN 32 |
| virt_on | input | 1 | Hart is running virtualized |
| vgein | input | 6 | Hypervisor guest-file selector |
| geilen | input | 6 | Number of guest files currently live |
| csr_rdata | output | 64 | Read data, always zero |
| exc_illegal | output | 1 | Illegal-instruction exception for this access |
| exc_virt | output | 1 | Virtual-instruction fault for this access |
| pend_o | output | (2+NUM_GUESTS)*NUM_IDS | Pending bits of all files |
| en_o | output | (2+NUM_GUESTS)*NUM_IDS | Enable bits of all files |

## Verification
The main instance uses the default parameters: 64 identities, so each file has two 32-bit words, and three guest files. The bench sweeps identities 0 to 66 through all four operations on the machine file, the supervisor file and two guest files, in both XLEN modes. This covers the word boundary at 31/32, the upper half of a 64-bit register and the out-of-range identities. `geilen` is changed at run time so that the live-count check and the NUM_GUESTS check can each reject an access on their own. A second instance is built with no supervisor file, 32 identities and one guest. It shows the absent-level exception and the redirect to a guest file when no supervisor file exists.

// File: rtl/intnum_pkg.sv
package intnum_pkg;

  typedef enum logic [1:0] {
    LVL_M   = 2'd0,
    LVL_S   = 2'd1,
    LVL_VS  = 2'd2,
    LVL_RSV = 2'd3
  } level_e;

  // Register index of an identity: (id / XLEN) * (XLEN / 32)
  function automatic logic [31:0] f_reg_index(input logic [63:0] id, input logic x64);
    logic [63:0] r;
    if (x64) r = (id / 64) * 2;
    else     r = id / 32;
    return r[31:0];
  endfunction

  // Bit position inside an XLEN-wide register: id mod XLEN
  function automatic logic [31:0] f_reg_bit(input logic [63:0] id, input logic x64);
    logic [63:0] r;
    if (x64) r = id % 64;
    else     r = id % 32;
    return r[31:0];
  endfunction

  // Physical 32-bit word that holds a register bit
  function automatic logic [31:0] f_phys_word(input logic [31:0] idx, input logic [31:0] rbit);
    return idx + (rbit / 32);
  endfunction

  function automatic logic [4:0] f_phys_bit(input logic [31:0] rbit);
    logic [31:0] r;
    r = rbit % 32;
    return r[4:0];
  endfunction

endpackage

// File: rtl/intnum_decode.sv
module intnum_decode
  import intnum_pkg::*;
#(
  parameter int NUM_GUESTS = 3,
  parameter bit HAS_M      = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter int GW         = 6,
  parameter int FW         = 3
) (
  input  logic          req,
  input  logic [3:0]    sel,
  input  logic          virt_on,
  input  logic [GW-1:0] vgein,
  input  logic [GW-1:0] geilen,
  output logic          file_ok,
  output logic [FW-1:0] file_idx,
  output logic          is_pend,
  output logic          is_set,
  output logic          exc_illegal,
  output logic          exc_virt
);

  level_e raw_lvl;
  level_e eff_lvl;
  logic   guest_ok;
  logic   invalid;

  assign raw_lvl = level_e'(sel[3:2]);
  assign is_pend = sel[1];
  assign is_set  = sel[0];

  // A supervisor access from a virtualized hart goes to the guest level
  assign eff_lvl = (virt_on && raw_lvl == LVL_S) ? LVL_VS : raw_lvl;

  assign guest_ok = (vgein != '0) && (vgein <= geilen) &&
                    (int'(vgein) <= NUM_GUESTS);

  always_comb begin
    file_ok  = 1'b0;
    file_idx = '0;
    unique case (eff_lvl)
      LVL_M:   begin file_ok = HAS_M; file_idx = FW'(0); end
      LVL_S:   begin file_ok = HAS_S; file_idx = FW'(1); end
      LVL_VS:  begin file_ok = guest_ok; file_idx = FW'(vgein) + FW'(1); end
      default: begin file_ok = 1'b0; file_idx = '0; end
    endcase
  end

  assign invalid     = req && !file_ok;
  assign exc_virt    = invalid && virt_on && (eff_lvl == LVL_VS);
  assign exc_illegal = invalid && !exc_virt;

endmodule

// File: rtl/intnum_locate.sv
module intnum_locate
  import intnum_pkg::*;
#(
  parameter int NUM_IDS = 64,
  parameter int WW      = 1
) (
  input  logic [63:0]   id,
  input  logic          xlen64,
  output logic [WW-1:0] word,
  output logic [4:0]    wbit
);

  logic [31:0] reg_idx;
  logic [31:0] reg_bit;
  logic [31:0] phys;

  assign reg_idx = f_reg_index(id, xlen64);
  assign reg_bit = f_reg_bit(id, xlen64);
  assign phys    = f_phys_word(reg_idx, reg_bit);
  assign word    = phys[WW-1:0];
  assign wbit    = f_phys_bit(reg_bit);

endmodule

// File: rtl/intnum_bank.sv
module intnum_bank #(
  parameter int NUM_IDS = 64,
  parameter int WW      = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_pend,
  input  logic               wr_val,
  input  logic [WW-1:0]      wr_word,
  input  logic [4:0]         wr_bit,
  output logic [NUM_IDS-1:0] pend_o,
  output logic [NUM_IDS-1:0] en_o
);

  localparam int NW = NUM_IDS / 32;

  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [31:0] pend_q;
    logic [31:0] en_q;
    logic        hit;

    assign hit = wr_en && (wr_word == WW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= '0;
        en_q   <= '0;
      end else if (hit) begin
        if (wr_pend) pend_q[wr_bit] <= wr_val;
        else         en_q[wr_bit]   <= wr_val;
      end
    end

    assign pend_o[w*32 +: 32] = pend_q;
    assign en_o[w*32 +: 32]   = en_q;
  end

endmodule

// File: rtl/intnum_csr_unit.sv
module intnum_csr_unit
  import intnum_pkg::*;
#(
  parameter int NUM_IDS    = 64,
  parameter int NUM_GUESTS = 3,
  parameter bit HAS_M      = 1'b1,
  parameter bit HAS_S      = 1'b1,
  parameter int NUM_FILES  = 2 + NUM_GUESTS
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         csr_req,
  input  logic [3:0]                   csr_sel,
  input  logic [63:0]                  csr_wdata,
  input  logic [63:0]                  csr_wmask,
  input  logic                         xlen64,
  input  logic                         virt_on,
  input  logic [5:0]                   vgein,
  input  logic [5:0]                   geilen,
  output logic [63:0]                  csr_rdata,
  output logic                         exc_illegal,
  output logic                         exc_virt,
  output logic [NUM_FILES*NUM_IDS-1:0] pend_o,
  output logic [NUM_FILES*NUM_IDS-1:0] en_o
);

  localparam int NW = NUM_IDS / 32;
  localparam int WW = (NW > 1) ? $clog2(NW) : 1;
  localparam int FW = $clog2(NUM_FILES);

  logic          file_ok;
  logic [FW-1:0] file_idx;
  logic          is_pend;
  logic          is_set;
  logic [63:0]   id;
  logic          id_in_range;
  logic          do_write;
  logic [WW-1:0] tgt_word;
  logic [4:0]    tgt_bit;

  intnum_decode #(
    .NUM_GUESTS(NUM_GUESTS), .HAS_M(HAS_M), .HAS_S(HAS_S), .GW(6), .FW(FW)
  ) u_dec (
    .req(csr_req), .sel(csr_sel), .virt_on(virt_on), .vgein(vgein), .geilen(geilen),
    .file_ok(file_ok), .file_idx(file_idx), .is_pend(is_pend), .is_set(is_set),
    .exc_illegal(exc_illegal), .exc_virt(exc_virt)
  );

  // Identity carried by the write; the upper half is dropped at XLEN 32
  assign id = xlen64 ? (csr_wdata & csr_wmask)
                     : {32'd0, csr_wdata[31:0] & csr_wmask[31:0]};

  assign id_in_range = (id != 64'd0) && (id < 64'(NUM_IDS));
  assign do_write    = csr_req && file_ok && id_in_range;

  intnum_locate #(.NUM_IDS(NUM_IDS), .WW(WW)) u_loc (
    .id(id), .xlen64(xlen64), .word(tgt_word), .wbit(tgt_bit)
  );

  for (genvar f = 0; f < NUM_FILES; f++) begin : g_file
    intnum_bank #(.NUM_IDS(NUM_IDS), .WW(WW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(do_write && (file_idx == FW'(f))),
      .wr_pend(is_pend), .wr_val(is_set),
      .wr_word(tgt_word), .wr_bit(tgt_bit),
      .pend_o(pend_o[f*NUM_IDS +: NUM_IDS]),
      .en_o(en_o[f*NUM_IDS +: NUM_IDS])
    );
  end

  assign csr_rdata = 64'd0;

endmodule

// File: rtl/intnum_csr_unit_chk.sv
module intnum_csr_unit_chk #(
  parameter int W = 320
) (
  input logic         clk,
  input logic         rst_n,
  input logic         csr_req,
  input logic [63:0]  csr_wmask,
  input logic         exc_illegal,
  input logic         exc_virt,
  input logic [W-1:0] pend_o,
  input logic [W-1:0] en_o
);

  // R4: an access changes at most one bit across every file
  p_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    csr_req |=> ($countones(pend_o ^ $past(pend_o)) + $countones(en_o ^ $past(en_o))) <= 1);

  // R4: with no access, the state does not move
  p_idle_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |=> ($stable(pend_o) && $stable(en_o)));

  // R9: a faulting access leaves the state untouched
  p_exc_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_illegal || exc_virt) |=> ($stable(pend_o) && $stable(en_o)));

  // R9: exceptions only accompany an access
  p_exc_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_req |-> !(exc_illegal || exc_virt));

  // R10: an all-zero mask writes nothing
  p_zero_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_wmask == 64'd0) |=> ($stable(pend_o) && $stable(en_o)));

endmodule

bind intnum_csr_unit intnum_csr_unit_chk #(.W(NUM_FILES*NUM_IDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_wmask(csr_wmask),
  .exc_illegal(exc_illegal), .exc_virt(exc_virt), .pend_o(pend_o), .en_o(en_o)
);

// File: tb/sim_intnum_csr_unit.sv
`timescale 1ns/1ps
module sim_intnum_csr_unit;

  localparam int NF  = 5;
  localparam int NI  = 64;
  localparam int TOT = NF * NI;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           req = 1'b0;
  logic [3:0]     sel = '0;
  logic [63:0]    wd = '0, wm = '0;
  logic           x64 = 1'b0, virt = 1'b0;
  logic [5:0]     vg = '0, gl = 6'd2;
  logic [63:0]    rdata;
  logic           e_ill, e_virt;
  logic [TOT-1:0] pend, en;

  // small instance: no supervisor file, 32 identities, one guest
  logic           b_req = 1'b0;
  logic [3:0]     b_sel = '0;
  logic [63:0]    b_wd = '0, b_wm = '0;
  logic           b_virt = 1'b0;
  logic [5:0]     b_vg = '0;
  logic [63:0]    b_rdata;
  logic           b_ill, b_vir;
  logic [95:0]    b_pend, b_en;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [TOT-1:0] mp = '0, me = '0;

  always #4 clk = ~clk;

  intnum_csr_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_req(req), .csr_sel(sel), .csr_wdata(wd),
    .csr_wmask(wm), .xlen64(x64), .virt_on(virt), .vgein(vg), .geilen(gl),
    .csr_rdata(rdata), .exc_illegal(e_ill), .exc_virt(e_virt),
    .pend_o(pend), .en_o(en)
  );

  intnum_csr_unit #(.NUM_IDS(32), .NUM_GUESTS(1), .HAS_M(1'b1), .HAS_S(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_req(b_req), .csr_sel(b_sel), .csr_wdata(b_wd),
    .csr_wmask(b_wm), .xlen64(1'b1), .virt_on(b_virt), .vgein(b_vg), .geilen(6'd1),
    .csr_rdata(b_rdata), .exc_illegal(b_ill), .exc_virt(b_vir),
    .pend_o(b_pend), .en_o(b_en)
  );

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // One access on u0, the model computed from the requirements
  task automatic acc(input logic [3:0] s, input logic [63:0] d, input logic [63:0] m,
                     input logic v, input logic [5:0] g, input string tag);
    int lvl, fidx;
    logic ok, xv, xi;
    logic [63:0] idv;
    lvl = int'(s[3:2]);
    if (v && lvl == 1) lvl = 2;                          // R7
    fidx = 0;
    ok = 1'b0;
    if (lvl == 0) begin ok = 1'b1; fidx = 0; end
    else if (lvl == 1) begin ok = 1'b1; fidx = 1; end
    else if (lvl == 2) begin
      ok = (g != 0) && (g <= gl) && (int'(g) <= 3);      // R6
      fidx = 1 + int'(g);
    end
    xv = !ok && v && (lvl == 2);                         // R9
    xi = !ok && !xv;
    idv = x64 ? (d & m) : {32'd0, d[31:0] & m[31:0]};    // R3 R11
    if (ok && idv != 0 && idv < 64) begin                // R5
      if (s[1]) mp[fidx*NI + int'(idv)] = s[0];
      else      me[fidx*NI + int'(idv)] = s[0];
    end
    sel = s; wd = d; wm = m; virt = v; vg = g; req = 1'b1;
    #1;
    chk(e_ill == xi, tag, "exc_illegal", 512'(e_ill), 512'(xi));
    chk(e_virt == xv, tag, "exc_virt", 512'(e_virt), 512'(xv));
    chk(rdata == 64'd0, "R2", "rdata", 512'(rdata), 512'd0);
    @(negedge clk);
    req = 1'b0;
    chk(pend == mp, tag, "pending", 512'(pend), 512'(mp));
    chk(en == me, tag, "enable", 512'(en), 512'(me));
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pend == '0 && en == '0, "R4", "reset state", 512'(pend | en), 512'd0);

    // R1 R3 R4 R5: sweep identities, files, operations and both XLEN modes
    for (int x = 0; x < 2; x++) begin
      x64 = x[0];
      for (int f = 0; f < 4; f++) begin
        for (int id = 0; id < 67; id++) begin
          for (int op = 0; op < 4; op++) begin
            logic [1:0] lv;
            logic [1:0] pk;
            lv = (f == 0) ? 2'd0 : (f == 1) ? 2'd1 : 2'd2;
            pk = (op == 0) ? 2'b11 : (op == 1) ? 2'b01 : (op == 2) ? 2'b10 : 2'b00;
            acc({lv, pk}, 64'hFFFF_FFFF_FFFF_FF00 | 64'(id), 64'h0000_0000_0000_00FF,
                1'b0, (f >= 2) ? 6'(f - 1) : 6'd0, "R3");
          end
        end
      end
    end

    // R4: two bits accumulate, and a clear removes only one of them
    x64 = 1'b1;
    acc(4'b0011, 64'd40, '1, 1'b0, 6'd0, "R4");
    acc(4'b0011, 64'd41, '1, 1'b0, 6'd0, "R4");
    acc(4'b0010, 64'd40, '1, 1'b0, 6'd0, "R4");
    acc(4'b0111, 64'd63, '1, 1'b0, 6'd0, "R4");

    // R11: the upper half is ignored at XLEN 32, and counts at XLEN 64
    x64 = 1'b0;
    acc(4'b0011, 64'h0000_0001_0000_0005, '1, 1'b0, 6'd0, "R11");
    acc(4'b0011, 64'd7, 64'hFFFF_FFFF_0000_0000, 1'b0, 6'd0, "R11");
    x64 = 1'b1;
    acc(4'b0011, 64'h0000_0001_0000_0009, '1, 1'b0, 6'd0, "R11");

    // R7: supervisor address while virtualized goes to guest file 1
    acc(4'b0111, 64'd12, '1, 1'b1, 6'd1, "R7");
    acc(4'b0101, 64'd13, '1, 1'b1, 6'd2, "R7");
    acc(4'b0011, 64'd14, '1, 1'b1, 6'd0, "R7");

    // R6 R9: guest selection checks and the fault kind
    acc(4'b0111, 64'd20, '1, 1'b1, 6'd0, "R6");
    acc(4'b0111, 64'd20, '1, 1'b1, 6'd3, "R6");
    acc(4'b1011, 64'd20, '1, 1'b0, 6'd0, "R9");
    acc(4'b1011, 64'd20, '1, 1'b0, 6'd3, "R9");
    gl = 6'd5;
    acc(4'b1011, 64'd21, '1, 1'b1, 6'd3, "R6");
    acc(4'b1011, 64'd21, '1, 1'b1, 6'd4, "R6");
    acc(4'b1011, 64'd21, '1, 1'b0, 6'd4, "R6");
    gl = 6'd2;

    // R8 R9: reserved level is illegal even when virtualized
    acc(4'b1111, 64'd22, '1, 1'b0, 6'd1, "R8");
    acc(4'b1111, 64'd22, '1, 1'b1, 6'd1, "R8");

    // R10: zero mask on valid and invalid accesses
    acc(4'b0011, 64'd30, 64'd0, 1'b0, 6'd0, "R10");
    acc(4'b1010, 64'd12, 64'd0, 1'b1, 6'd1, "R10");
    acc(4'b1011, 64'd30, 64'd0, 1'b1, 6'd0, "R10");

    // R5: identity 0 and out-of-range identities raise nothing
    acc(4'b0011, 64'd0, '1, 1'b0, 6'd0, "R5");
    acc(4'b0011, 64'd64, '1, 1'b0, 6'd0, "R5");
    acc(4'b1011, 64'h8000_0000_0000_0001, '1, 1'b0, 6'd1, "R5");

    // R8: absent supervisor file on the small instance
    b_sel = 4'b0111; b_wd = 64'd3; b_wm = '1; b_virt = 1'b0; b_vg = 6'd0; b_req = 1'b1;
    #1;
    chk(b_ill == 1'b1 && b_vir == 1'b0, "R8", "absent S exc",
        512'({b_ill, b_vir}), 512'(2'b10));
    @(negedge clk);
    chk(b_pend == '0 && b_en == '0, "R8", "absent S state", 512'(b_pend | b_en), 512'd0);
    b_virt = 1'b1; b_vg = 6'd1;
    #1;
    chk(b_ill == 1'b0 && b_vir == 1'b0, "R7", "small redirect exc",
        512'({b_ill, b_vir}), 512'd0);
    @(negedge clk);
    chk(b_pend == (96'd1 << 67), "R7", "small redirect state", 512'(b_pend), 512'(96'd1 << 67));
    b_sel = 4'b0001; b_virt = 1'b0; b_vg = 6'd0; b_wd = 64'd31;
    @(negedge clk);
    chk(b_en == (96'd1 << 31), "R1", "small M enable", 512'(b_en), 512'(96'd1 << 31));
    b_req = 1'b0;
    @(negedge clk);
    chk(b_rdata == 64'd0, "R2", "small rdata", 512'(b_rdata), 512'd0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule